// File: doc/BRIEF.md
# Reverse Map Entry Locator

This block turns a system physical address into the memory address of the 16-byte reverse-map entry that governs its 4KB page. It takes one lookup at a time through a request/response handshake and answers with a status code and, on success, the entry address. Reading the entry itself is left to the caller.

Two table layouts are supported. In the flat layout, entries follow a 16KB bookkeeping area at the configured base, and the configured end address bounds how many pages are covered. In the segmented layout, physical memory is cut into power-of-two spans. After the bookkeeping area sits a 4KB segment directory of 8-byte descriptors. For each lookup the block issues one 8-byte read of the matching descriptor over a valid/ready read port. Each descriptor gives a 1MB-aligned base for that span's entries and a mapped size in gigabytes. The block then decides whether the address is covered.

The configuration arrives as static register values: table base, table end, layout select, segment size exponent, and an optional hard limit on the number of descriptors.

Top module: `rmp_entry_locator`

## Requirements
- R1: While reset is held, and after it, with no request pending, `req_ready_o` is 1 and `rsp_valid_o` and `rd_valid_o` are 0.
- R2: In flat mode a covered address returns code 0 (ok) with address `base + 16384 + (pa >> 12) * 16`. A successful address always has its low 4 bits at zero.
- R3: In flat mode, page `pa >> 12` is covered only when `end + 1 - base >= 16384 + 16 * (page + 1)`. Otherwise the code is 1 (not covered). Any non-ok response carries address 0.
- R4: If base bits [12:0] are not all zero, or end bits [12:0] are not all one, the code is 2 (config error) in either mode, and no read is issued. Code 3 is never produced.
- R5: In segmented mode with an in-range index, exactly one read is issued, at `base + 16384 + index * 8`, where `index = pa >> shift`. The request holds its address stable until `rd_ready_i` is seen.
- R6: A segment index of 512 or more, or an index at or above `seg_cap_i` when `seg_cap_hard_i` is 1, returns code 1 with no read. When the limit is not flagged hard, the cap has no effect.
- R7: A descriptor whose mapped size (bits [19:0]) is zero returns code 1.
- R8: Let `off = pa - (index << shift)`. If `off >= mapped << 30`, the code is 1. Otherwise the code is 0 and the address is `{desc[51:20], 20'b0} + (off >> 12) * 16`.
- R9: `req_ready_o` is 0 from the accepted request until the response handshake completes. The response code and address stay stable while `rsp_valid_o` is 1 and `rsp_ready_i` is 0.
- R10: Flat mode never issues a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_base_i | input | PA_W | Address of the first byte of the table (bookkeeping area start) |
| tbl_end_i | input | PA_W | Address of the last byte of the table |
| seg_mode_i | input | 1 | 1 selects the segmented layout |
| seg_shift_i | input | 6 | log2 of the bytes covered by one segment |
| seg_cap_i | input | CAP_W | Number of usable segment descriptors |
| seg_cap_hard_i | input | 1 | 1 makes `seg_cap_i` a hard index limit |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_pa_i | input | PA_W | Physical address to locate |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_code_o | output | 2 | 0 ok, 1 not covered, 2 config error |
| rsp_addr_o | output | PA_W | Entry address when code is 0, else 0 |
| rd_valid_o | output | 1 | Descriptor read request |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | PA_W | 8-byte-aligned descriptor address |
| rd_data_valid_i | input | 1 | Descriptor data valid |
| rd_data_i | input | PA_W | Descriptor bits [PA_W-1:0] |

## Verification
The assertions assume the configuration inputs do not change while a lookup is in flight. The stimulus only changes base, end, layout, shift and cap between responses, when the engine is idle. The assertions also assume at most one data beat is returned per accepted read. The memory responder returns exactly one beat, after a random delay, for each read handshake. Random configurations keep the table base 1MB-aligned, so that successful addresses are 16-byte aligned. Misaligned configurations are injected on purpose and checked only against the config-error code.

// File: rtl/rmp_loc_pkg.sv
package rmp_loc_pkg;
  localparam int unsigned PAGE_SH     = 12;
  localparam int unsigned ENT_SH      = 4;
  localparam int unsigned BOOK_BYTES  = 16384;
  localparam int unsigned DESC_SH     = 3;
  localparam int unsigned DESC_SLOTS  = 512;
  localparam int unsigned MAP_W       = 20;
  localparam int unsigned GB_SH       = 30;
  localparam int unsigned ALIGN_SH    = 13;
  localparam int unsigned SEGBASE_LSB = 20;

  typedef enum logic [1:0] {
    RSP_OK     = 2'd0,
    RSP_NOCOV  = 2'd1,
    RSP_CFGERR = 2'd2
  } rsp_code_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_RESP
  } loc_state_e;
endpackage

// File: rtl/rmp_flat_calc.sv
module rmp_flat_calc
  import rmp_loc_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic [PA_W-1:0] base_i,
  input  logic [PA_W-1:0] end_i,
  input  logic [PA_W-1:0] pa_i,
  output logic            hit_o,
  output logic [PA_W-1:0] addr_o
);
  localparam int unsigned W  = PA_W + 2;
  localparam int unsigned PG = PA_W - PAGE_SH;

  logic [PG-1:0] page;
  logic [W-1:0]  span;
  logic [W-1:0]  need;

  assign page = pa_i[PA_W-1:PAGE_SH];
  // span goes negative (top bit set) when end precedes base
  assign span = W'(end_i) + W'(1) - W'(base_i);
  assign need = W'({page, {ENT_SH{1'b0}}}) + W'(1 << ENT_SH) + W'(BOOK_BYTES);

  assign hit_o  = !span[W-1] && (need <= span);
  assign addr_o = base_i + PA_W'(BOOK_BYTES) + PA_W'({page, {ENT_SH{1'b0}}});
endmodule

// File: rtl/rmp_seg_index.sv
module rmp_seg_index
  import rmp_loc_pkg::*;
#(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned CAP_W = 10
) (
  input  logic [PA_W-1:0]  pa_i,
  input  logic [5:0]       shift_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic             cap_hard_i,
  output logic             ok_o,
  output logic [PA_W-1:0]  desc_addr_o
);
  localparam int unsigned IDX_W = $clog2(DESC_SLOTS);

  logic [PA_W-1:0] idx;
  logic            in_dir;
  logic            under_cap;

  assign idx       = pa_i >> shift_i;
  assign in_dir    = idx < PA_W'(DESC_SLOTS);
  assign under_cap = !cap_hard_i || (idx < PA_W'(cap_i));
  assign ok_o      = in_dir && under_cap;

  assign desc_addr_o = base_i + PA_W'(BOOK_BYTES)
                     + PA_W'({idx[IDX_W-1:0], {DESC_SH{1'b0}}});
endmodule

// File: rtl/rmp_seg_resolve.sv
module rmp_seg_resolve
  import rmp_loc_pkg::*;
#(
  parameter int unsigned PA_W = 52
) (
  input  logic [PA_W-1:0] pa_i,
  input  logic [5:0]      shift_i,
  input  logic [PA_W-1:0] desc_i,
  output logic            hit_o,
  output logic [PA_W-1:0] addr_o
);
  localparam int unsigned CW = PA_W + GB_SH;

  logic [PA_W-1:0]  mask;
  logic [PA_W-1:0]  off;
  logic [MAP_W-1:0] mapped;
  logic [CW-1:0]    lim;
  logic [PA_W-1:0]  seg_base;

  // shift >= PA_W leaves an all-ones mask
  assign mask   = ~({PA_W{1'b1}} << shift_i);
  assign off    = pa_i & mask;
  assign mapped = desc_i[MAP_W-1:0];
  assign lim    = CW'(mapped) << GB_SH;
  assign hit_o  = (mapped != '0) && (CW'(off) < lim);

  assign seg_base = {desc_i[PA_W-1:SEGBASE_LSB], {SEGBASE_LSB{1'b0}}};
  assign addr_o   = seg_base + PA_W'({off[PA_W-1:PAGE_SH], {ENT_SH{1'b0}}});
endmodule

// File: rtl/rmp_entry_locator.sv
module rmp_entry_locator
  import rmp_loc_pkg::*;
#(
  parameter int unsigned PA_W  = 52,
  parameter int unsigned CAP_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PA_W-1:0]  tbl_base_i,
  input  logic [PA_W-1:0]  tbl_end_i,
  input  logic             seg_mode_i,
  input  logic [5:0]       seg_shift_i,
  input  logic [CAP_W-1:0] seg_cap_i,
  input  logic             seg_cap_hard_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [PA_W-1:0]  req_pa_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [1:0]       rsp_code_o,
  output logic [PA_W-1:0]  rsp_addr_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [PA_W-1:0]  rd_addr_o,
  input  logic             rd_data_valid_i,
  input  logic [PA_W-1:0]  rd_data_i
);
  loc_state_e      state_q;
  logic [PA_W-1:0] pa_q;
  logic [PA_W-1:0] desc_q;
  rsp_code_e       code_q, code_d;
  logic [PA_W-1:0] addr_q, addr_d;

  logic            cfg_aligned;
  logic [PA_W-1:0] idx_pa;
  logic            idx_ok;
  logic [PA_W-1:0] desc_addr;
  logic            flat_hit, seg_hit;
  logic [PA_W-1:0] flat_addr, seg_addr;

  assign cfg_aligned = (tbl_base_i[ALIGN_SH-1:0] == '0) && (&tbl_end_i[ALIGN_SH-1:0]);
  // index path sees the live request while idle, the held one afterwards
  assign idx_pa = (state_q == S_IDLE) ? req_pa_i : pa_q;

  rmp_seg_index #(.PA_W(PA_W), .CAP_W(CAP_W)) u_idx (
    .pa_i        (idx_pa),
    .shift_i     (seg_shift_i),
    .base_i      (tbl_base_i),
    .cap_i       (seg_cap_i),
    .cap_hard_i  (seg_cap_hard_i),
    .ok_o        (idx_ok),
    .desc_addr_o (desc_addr)
  );

  rmp_flat_calc #(.PA_W(PA_W)) u_flat (
    .base_i (tbl_base_i),
    .end_i  (tbl_end_i),
    .pa_i   (pa_q),
    .hit_o  (flat_hit),
    .addr_o (flat_addr)
  );

  rmp_seg_resolve #(.PA_W(PA_W)) u_res (
    .pa_i    (pa_q),
    .shift_i (seg_shift_i),
    .desc_i  (desc_q),
    .hit_o   (seg_hit),
    .addr_o  (seg_addr)
  );

  always_comb begin
    code_d = RSP_CFGERR;
    addr_d = '0;
    if (cfg_aligned) begin
      if (!seg_mode_i) begin
        code_d = flat_hit ? RSP_OK : RSP_NOCOV;
        addr_d = flat_hit ? flat_addr : '0;
      end else if (idx_ok && seg_hit) begin
        code_d = RSP_OK;
        addr_d = seg_addr;
      end else begin
        code_d = RSP_NOCOV;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pa_q    <= '0;
      desc_q  <= '0;
      code_q  <= RSP_OK;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          pa_q    <= req_pa_i;
          state_q <= (cfg_aligned && seg_mode_i && idx_ok) ? S_FETCH : S_CHECK;
        end
        S_FETCH: if (rd_ready_i) state_q <= S_WAIT;
        S_WAIT: if (rd_data_valid_i) begin
          desc_q  <= rd_data_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          code_q  <= code_d;
          addr_q  <= addr_d;
          state_q <= S_RESP;
        end
        S_RESP: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign rd_valid_o  = (state_q == S_FETCH);
  assign rd_addr_o   = desc_addr;
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_code_o  = code_q;
  assign rsp_addr_o  = addr_q;
endmodule

// File: rtl/rmp_loc_checker.sv
module rmp_loc_checker #(
  parameter int unsigned PA_W = 52
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            seg_mode_i,
  input logic            req_ready_o,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [1:0]      rsp_code_o,
  input logic [PA_W-1:0] rsp_addr_o,
  input logic            rd_valid_o,
  input logic            rd_ready_i,
  input logic [PA_W-1:0] rd_addr_o
);
  AST_OK_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o == 2'd0 |-> rsp_addr_o[3:0] == 4'd0); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_code_o != 2'd0 |-> rsp_addr_o == '0); // R3
  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_code_o != 2'd3); // R4
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R5
  AST_RD_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_addr_o[2:0] == 3'd0); // R5
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_code_o) && $stable(rsp_addr_o)); // R9
  AST_SINGLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o || rd_valid_o |-> !req_ready_o); // R9
  AST_FLAT_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> seg_mode_i); // R10
endmodule

bind rmp_entry_locator rmp_loc_checker #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seg_mode_i  (seg_mode_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_code_o  (rsp_code_o),
  .rsp_addr_o  (rsp_addr_o),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .rd_addr_o   (rd_addr_o)
);

// File: tb/sim_rmp_entry_locator.sv
module sim_rmp_entry_locator;
  localparam int unsigned PA_W = 52;
  localparam logic [63:0] M52 = (64'd1 << 52) - 64'd1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PA_W-1:0] base = '0, endr = '0;
  logic            seg_mode = 1'b0;
  logic [5:0]      shift = 6'd30;
  logic [9:0]      cap = 10'd0;
  logic            cap_hard = 1'b0;
  logic            req_valid = 1'b0;
  logic [PA_W-1:0] req_pa = '0;
  logic            rsp_ready = 1'b0;
  logic            rd_ready = 1'b0;
  logic            rd_dv = 1'b0;
  logic [PA_W-1:0] rd_data = '0;
  logic            req_ready, rsp_valid, rd_valid;
  logic [1:0]      rsp_code;
  logic [PA_W-1:0] rsp_addr, rd_addr;

  logic [PA_W-1:0] dir_mem [16];
  int              reads = 0;
  logic [PA_W-1:0] last_rd = '0;
  int              checks = 0, fails = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  rmp_entry_locator #(.PA_W(PA_W), .CAP_W(10)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_base_i(base), .tbl_end_i(endr), .seg_mode_i(seg_mode),
    .seg_shift_i(shift), .seg_cap_i(cap), .seg_cap_hard_i(cap_hard),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_pa_i(req_pa),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_code_o(rsp_code), .rsp_addr_o(rsp_addr),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rd_data_valid_i(rd_dv), .rd_data_i(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  // descriptor memory responder
  initial forever begin
    @(negedge clk);
    rd_ready = 1'b0;
    rd_dv = 1'b0;
    if (rd_valid) begin
      repeat ($urandom % 3) @(negedge clk);
      rd_ready = 1'b1;
      last_rd = rd_addr;
      reads++;
      @(negedge clk);
      rd_ready = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      rd_data = dir_mem[((64'(last_rd) - 64'(base) - 64'd16384) >> 3) & 64'd15];
      rd_dv = 1'b1;
      @(negedge clk);
      rd_dv = 1'b0;
    end
  end

  task automatic model(input logic [63:0] p, output logic [1:0] st, output logic [63:0] ea,
                       output int nrd, output logic [63:0] raddr);
    logic [63:0] b, e, idx, off, ent, mp;
    b = 64'(base); e = 64'(endr);
    st = 2'd1; ea = 64'd0; nrd = 0; raddr = 64'd0;
    if (b[12:0] != 13'd0 || e[12:0] != 13'h1fff) begin
      st = 2'd2;
    end else if (!seg_mode) begin
      if (e + 64'd1 >= b + 64'd16384 + 64'd16 * ((p >> 12) + 64'd1)) begin
        st = 2'd0;
        ea = (b + 64'd16384 + (p >> 12) * 64'd16) & M52;
      end
    end else begin
      idx = p >> shift;
      if (idx < 64'd512 && !(cap_hard && idx >= 64'(cap))) begin
        nrd = 1;
        raddr = (b + 64'd16384 + idx * 64'd8) & M52;
        ent = 64'(dir_mem[idx[3:0]]);
        mp = ent & 64'hfffff;
        off = p - (idx << shift);
        if (mp != 64'd0 && off < (mp << 30)) begin
          st = 2'd0;
          ea = ((ent & 64'h000f_ffff_fff0_0000) + (off >> 12) * 64'd16) & M52;
        end
      end
    end
  endtask

  task automatic run(input logic [63:0] p, input string tag);
    logic [1:0]  st;
    logic [63:0] ea, ra;
    int          nrd, r0;
    model(p & M52, st, ea, nrd, ra);
    r0 = reads;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_pa = PA_W'(p);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    repeat ($urandom % 3) @(negedge clk);
    chk(req_ready == 1'b0, {tag, " R9 busy"}, 64'(req_ready), 64'd0);
    chk(rsp_code == st, {tag, " code R2 R3 R4 R6 R7 R8"}, 64'(rsp_code), 64'(st));
    chk(64'(rsp_addr) == ea, {tag, " addr R2 R8"}, 64'(rsp_addr), ea);
    chk(reads - r0 == nrd, {tag, " read count R5 R6 R10"}, 64'(reads - r0), 64'(nrd));
    if (nrd == 1) chk(64'(last_rd) == ra, {tag, " read addr R5"}, 64'(last_rd), ra);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic set_flat(input logic [63:0] b, input logic [63:0] pages);
    seg_mode = 1'b0;
    base = PA_W'(b);
    endr = PA_W'(b + 64'd16384 + pages * 64'd16 - 64'd1);
  endtask

  task automatic set_seg(input logic [63:0] b, input logic [5:0] sh);
    seg_mode = 1'b1;
    base = PA_W'(b);
    endr = PA_W'(b + 64'h10_0000 - 64'd1);
    shift = sh;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) dir_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp in reset", 64'(rsp_valid), 64'd0);
    chk(rd_valid == 1'b0, "R1 rd in reset", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && rd_valid == 1'b0, "R1 after reset",
        {61'd0, req_ready, rsp_valid, rd_valid}, 64'd4);

    // flat layout, 512 pages
    set_flat(64'h10_0000, 64'd512);
    run(64'h123, "R2 first page");
    run(64'd511 << 12 | 64'hfff, "R2 last page");
    run(64'd512 << 12, "R3 first uncovered page");
    run(64'h8_0000_0000, "R3 far address");
    set_flat(64'h10_0000, 64'd0);
    run(64'd0, "R3 bookkeeping only");
    // misaligned configuration
    set_flat(64'h10_1000, 64'd512);
    run(64'h5000, "R4 base misaligned");
    set_flat(64'h10_0000, 64'd512);
    endr = endr - 1;
    run(64'h5000, "R4 end misaligned");
    set_seg(64'h20_1000, 6'd30);
    run(64'h4000_0000, "R4 seg misaligned");

    // segmented layout, 1GB segments
    set_seg(64'h20_0000, 6'd30);
    cap = 10'd0; cap_hard = 1'b0;
    dir_mem[0]  = '0;
    dir_mem[1]  = PA_W'((64'hABC << 20) | 64'd1);
    dir_mem[2]  = PA_W'((64'h123 << 20) | 64'd2);
    dir_mem[3]  = PA_W'((64'h7 << 20) | 64'd1);
    dir_mem[15] = PA_W'((64'h55 << 20) | 64'd1);
    run(64'h1234, "R7 zero mapped size");
    run((64'd1 << 30) + 64'h5000, "R8 seg1 hit");
    run((64'd511 << 30) + 64'h3000, "R5 last slot");
    run(64'd512 << 30, "R6 beyond directory");
    // 4GB segments, partial mapping
    shift = 6'd32;
    run((64'd2 << 32) + (64'd2 << 30) - 64'd1, "R8 last mapped byte");
    run((64'd2 << 32) + (64'd2 << 30), "R8 mapped limit");
    // hard cap
    shift = 6'd30; cap = 10'd4; cap_hard = 1'b1;
    run((64'd3 << 30) + 64'h1000, "R6 below hard cap");
    run((64'd4 << 30) + 64'h1000, "R6 at hard cap");
    cap_hard = 1'b0;
    run((64'd4 << 30) + 64'h1000, "R6 soft cap ignored");

    // random mix
    for (int i = 0; i < 16; i++)
      dir_mem[i] = PA_W'(((r64() & 64'hffff_ffff) << 20) | (($urandom % 8 == 0) ? 64'd0 : 64'($urandom % 8)));
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 2 == 0) begin
        logic [63:0] pg;
        pg = 64'(($urandom % 64) + 1) * 64'd512;
        set_flat(64'($urandom % 4096) << 20, pg);
        if ($urandom % 10 == 0) base = base | PA_W'(64'h1000);
        run((64'($urandom) % (pg + pg / 8 + 1)) << 12 | 64'($urandom % 4096), "R2 R3 random flat");
      end else begin
        logic [5:0]  sh;
        logic [63:0] idx;
        sh = 6'(30 + $urandom % 7);
        set_seg(64'($urandom % 4096) << 20, sh);
        cap = 10'($urandom % 24);
        cap_hard = 1'($urandom % 2);
        idx = 64'($urandom % 24);
        if ($urandom % 8 == 0) begin
          shift = 6'd30;
          idx = 64'(500 + $urandom % 20);
        end
        if ($urandom % 12 == 0) endr = endr - 1;
        run((idx << shift) | (r64() & ((64'd1 << shift) - 64'd1)), "R5 R6 R7 R8 random seg");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 64'd1, 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule